// File: doc/BRIEF.md
# Prioritized Interrupt Vector Selector

This block sits beside a small CPU core and decides, at each instruction boundary, which pending event the core services next. It watches six request lines (reset, non-maskable interrupt, maskable interrupt, and three timer events: capture, compare match and counter overflow). It also watches the core's interrupt-mask flag and one enable bit for each timer event. The highest-priority request that is pending wins. If that request may be serviced, the block pulses a take strobe for one cycle. With the strobe it presents the 16-bit vector address and a one-hot acknowledge, which the requester uses to clear its request.

A masked winner is not dropped. It stays pending and hides every lower request at that boundary. When a reset request is serviced, the block also pulses a clear line that wipes the timer control/status byte and its "status was read" tracking flag.

All outputs are registered. A decision made on a clock edge where the boundary input is high shows up on the outputs after that edge. The cycle that carries a take strobe makes no new decision, because the acknowledge is still on its way to the requester.

Top module: `irq_vector_sel`

## Requirements
- R1: After the synchronous reset `rst`, take_o, ack_o, vector_o and tmr_status_clr_o are all 0, and vector_o and ack_o stay 0 in every cycle where take_o is 0.
- R2: An edge where boundary_i is low makes no decision, so take_o is 0 after that edge whatever the request lines are.
- R3: Priority from highest to lowest is reset, NMI, IRQ, input capture, output compare, timer overflow. Only the highest pending request is considered at a boundary.
- R4: A reset request is taken regardless of mask and enables, with vector 0xFFFE, and tmr_status_clr_o pulses together with its take strobe.
- R5: An NMI request is taken regardless of mask_i, with vector 0xFFFC.
- R6: An IRQ request is taken only when mask_i is 0, with vector 0xFFF8.
- R7: An input-capture request is taken only when mask_i is 0 and en_icap_i is 1, with vector 0xFFF6.
- R8: An output-compare request is taken only when mask_i is 0 and en_ocmp_i is 1, with vector 0xFFF4.
- R9: A timer-overflow request is taken only when mask_i is 0 and en_tovf_i is 1, with vector 0xFFF2.
- R10: If the highest pending request is masked or disabled, nothing is taken at that boundary. take_o and ack_o stay 0, even when a lower serviceable request is pending.
- R11: take_o is a one-cycle pulse. The edge that follows a take makes no decision, so with boundary_i held high and a request left pending, takes come on alternate cycles.
- R12: While take_o is 1, exactly one ack_o bit is set. The bit is 0 for reset, 1 for NMI, 2 for IRQ, 3 for input capture, 4 for output compare and 5 for timer overflow, and it matches vector_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the selector itself |
| boundary_i | input | 1 | High on cycles that end an instruction |
| req_reset_i | input | 1 | Reset request |
| req_nmi_i | input | 1 | Non-maskable interrupt request |
| req_irq_i | input | 1 | Maskable interrupt request |
| req_icap_i | input | 1 | Timer input-capture request |
| req_ocmp_i | input | 1 | Timer output-compare request |
| req_tovf_i | input | 1 | Timer overflow request |
| mask_i | input | 1 | CPU interrupt-mask flag (1 = maskable sources blocked) |
| en_icap_i | input | 1 | Input-capture interrupt enable |
| en_ocmp_i | input | 1 | Output-compare interrupt enable |
| en_tovf_i | input | 1 | Overflow interrupt enable |
| take_o | output | 1 | One-cycle strobe: service an event now |
| vector_o | output | 16 | Vector address of the serviced event |
| ack_o | output | 6 | One-hot acknowledge of the serviced source |
| tmr_status_clr_o | output | 1 | Clears timer status byte and read-tracking flag |

## Verification
Each source is first driven alone, with the mask and enables set for it and against it. This separates the per-source gating from the vector encoding. Pairs and full sets of requests then show that only the top request counts. The key case is a masked IRQ or disabled timer source above a serviceable one, which tells "blocked" apart from "skipped to the next". Random request, mask and enable patterns are compared with a priority model. Directed cases cover a boundary held high over several cycles and requests that arrive while the boundary input is low.

// File: rtl/ivs_pkg.sv
package ivs_pkg;

    localparam int NSRC  = 6;
    localparam int VEC_W = 16;
    localparam int IDX_W = $clog2(NSRC);
    localparam int NTMR  = 3;
    localparam int TMR_BASE = 3;

    typedef enum logic [IDX_W-1:0] {
        SRC_RESET = 3'd0,
        SRC_NMI   = 3'd1,
        SRC_IRQ   = 3'd2,
        SRC_ICAP  = 3'd3,
        SRC_OCMP  = 3'd4,
        SRC_TOVF  = 3'd5
    } src_e;

    typedef struct packed {
        logic pending;
        logic take;
        src_e src;
    } pick_t;

    typedef struct packed {
        logic             take;
        logic             clr;
        logic [NSRC-1:0]  ack;
        logic [VEC_W-1:0] vector;
    } verdict_t;

    function automatic logic [VEC_W-1:0] vector_of(src_e s);
        case (s)
            SRC_RESET: return 16'hFFFE;
            SRC_NMI:   return 16'hFFFC;
            SRC_IRQ:   return 16'hFFF8;
            SRC_ICAP:  return 16'hFFF6;
            SRC_OCMP:  return 16'hFFF4;
            default:   return 16'hFFF2;
        endcase
    endfunction

    function automatic logic [NSRC-1:0] onehot_of(src_e s);
        logic [NSRC-1:0] v;
        v = '0;
        v[s] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/ivs_gate.sv
module ivs_gate
    import ivs_pkg::*;
(
    input  logic            mask_i,
    input  logic [NTMR-1:0] tmr_en_i,
    output logic [NSRC-1:0] allow_o
);
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        if (g < int'(SRC_IRQ)) begin : g_nomask
            assign allow_o[g] = 1'b1;
        end else if (g == int'(SRC_IRQ)) begin : g_mask
            assign allow_o[g] = ~mask_i;
        end else begin : g_tmr
            assign allow_o[g] = ~mask_i & tmr_en_i[g-TMR_BASE];
        end
    end
endmodule

// File: rtl/ivs_prio.sv
module ivs_prio
    import ivs_pkg::*;
(
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] allow_i,
    output pick_t           pick_o
);
    always_comb begin
        pick_o = '{pending: 1'b0, take: 1'b0, src: SRC_RESET};
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                pick_o.pending = 1'b1;
                pick_o.src     = src_e'(i[IDX_W-1:0]);
                pick_o.take    = allow_i[i];
            end
        end
    end
endmodule

// File: rtl/ivs_out_reg.sv
module ivs_out_reg
    import ivs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     decide_i,
    input  pick_t    pick_i,
    output verdict_t verdict_o
);
    verdict_t nxt;

    always_comb begin
        nxt = '0;
        if (decide_i && pick_i.pending && pick_i.take) begin
            nxt.take   = 1'b1;
            nxt.clr    = (pick_i.src == SRC_RESET);
            nxt.ack    = onehot_of(pick_i.src);
            nxt.vector = vector_of(pick_i.src);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) verdict_o <= '0;
        else     verdict_o <= nxt;
    end

    assert_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        verdict_o.take |=> !verdict_o.take);
    assert_ack_onehot_R12: assert property (@(posedge clk) disable iff (rst)
        verdict_o.take |-> $countones(verdict_o.ack) == 1);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !verdict_o.take |-> (verdict_o.ack == '0 && verdict_o.vector == '0 && !verdict_o.clr));
endmodule

// File: rtl/irq_vector_sel.sv
module irq_vector_sel
    import ivs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        boundary_i,
    input  logic        req_reset_i,
    input  logic        req_nmi_i,
    input  logic        req_irq_i,
    input  logic        req_icap_i,
    input  logic        req_ocmp_i,
    input  logic        req_tovf_i,
    input  logic        mask_i,
    input  logic        en_icap_i,
    input  logic        en_ocmp_i,
    input  logic        en_tovf_i,
    output logic        take_o,
    output logic [15:0] vector_o,
    output logic [5:0]  ack_o,
    output logic        tmr_status_clr_o
);
    logic [NSRC-1:0] req;
    logic [NSRC-1:0] allow;
    pick_t           pick;
    verdict_t        verdict;
    logic            decide;

    assign req = {req_tovf_i, req_ocmp_i, req_icap_i, req_irq_i, req_nmi_i, req_reset_i};

    ivs_gate u_gate (
        .mask_i   (mask_i),
        .tmr_en_i ({en_tovf_i, en_ocmp_i, en_icap_i}),
        .allow_o  (allow)
    );

    ivs_prio u_prio (
        .req_i   (req),
        .allow_i (allow),
        .pick_o  (pick)
    );

    // The edge after a take is skipped: the acknowledge has not reached the requester yet.
    assign decide = boundary_i & ~verdict.take;

    ivs_out_reg u_out (
        .clk       (clk),
        .rst       (rst),
        .decide_i  (decide),
        .pick_i    (pick),
        .verdict_o (verdict)
    );

    assign take_o           = verdict.take;
    assign vector_o         = verdict.vector;
    assign ack_o            = verdict.ack;
    assign tmr_status_clr_o = verdict.clr;

    assert_no_boundary_R2: assert property (@(posedge clk) disable iff (rst)
        !boundary_i |=> !take_o);
    assert_clr_is_reset_R4: assert property (@(posedge clk) disable iff (rst)
        tmr_status_clr_o |-> (take_o && vector_o == 16'hFFFE && ack_o[0]));
    assert_nmi_unmasked_R5: assert property (@(posedge clk) disable iff (rst)
        (boundary_i && !take_o && req_nmi_i && !req_reset_i) |=> (take_o && vector_o == 16'hFFFC));
    assert_mask_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        (mask_i && !req_reset_i && !req_nmi_i) |=> !take_o);
endmodule

// File: tb/irq_vector_sel_tb_top.sv
module irq_vector_sel_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic boundary = 1'b0;
    logic [5:0] req = '0;
    logic mask = 1'b0;
    logic [2:0] en = '0;
    logic take, clr;
    logic [15:0] vec;
    logic [5:0] ack;
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    irq_vector_sel dut_i (
        .clk(clk), .rst(rst), .boundary_i(boundary),
        .req_reset_i(req[0]), .req_nmi_i(req[1]), .req_irq_i(req[2]),
        .req_icap_i(req[3]), .req_ocmp_i(req[4]), .req_tovf_i(req[5]),
        .mask_i(mask), .en_icap_i(en[0]), .en_ocmp_i(en[1]), .en_tovf_i(en[2]),
        .take_o(take), .vector_o(vec), .ack_o(ack), .tmr_status_clr_o(clr)
    );

    // Model: {take, clr, ack[5:0], vector[15:0]}
    function automatic logic [23:0] model(logic [5:0] r, logic m, logic [2:0] e);
        logic [15:0] vt [6];
        logic ok;
        vt = '{16'hFFFE, 16'hFFFC, 16'hFFF8, 16'hFFF6, 16'hFFF4, 16'hFFF2};
        for (int i = 0; i < 6; i++) begin
            if (r[i]) begin
                if (i < 2)       ok = 1'b1;
                else if (i == 2) ok = !m;
                else             ok = !m && e[i-3];
                if (!ok) return '0;
                return {1'b1, (i == 0), 6'(1 << i), vt[i]};
            end
        end
        return '0;
    endfunction

    function automatic string tag_of(logic [5:0] r, logic m, logic [2:0] e);
        string t [6];
        t = '{"R4", "R5", "R6", "R7", "R8", "R9"};
        for (int i = 0; i < 6; i++)
            if (r[i]) begin
                if (model(r, m, e) == '0) return "R10";
                return (r & ((6'd1 << i) - 6'd1)) == 0 && $countones(r) > 1 ? {t[i], "/R3/R12"} : {t[i], "/R12"};
            end
        return "R10";
    endfunction

    task automatic check(string tg, logic [23:0] got, logic [23:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tg, got, exp);
        end
    endtask

    task automatic trial(logic [5:0] r, logic m, logic [2:0] e);
        @(negedge clk);
        req = r; mask = m; en = e; boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
        check(tag_of(r, m, e), {take, clr, ack, vec}, model(r, m, e));
        @(negedge clk);
        check("R2", {take, clr, ack, vec}, '0);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog got=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {take, clr, ack, vec}, '0);

        // single sources, with and without mask / enable
        trial(6'b000001, 1'b1, 3'b000);  // R4 despite mask
        trial(6'b000010, 1'b1, 3'b000);  // R5 despite mask
        trial(6'b000100, 1'b0, 3'b000);  // R6
        trial(6'b000100, 1'b1, 3'b111);  // R6 masked
        trial(6'b001000, 1'b0, 3'b001);  // R7
        trial(6'b001000, 1'b0, 3'b110);  // R7 disabled
        trial(6'b001000, 1'b1, 3'b111);  // R7 masked
        trial(6'b010000, 1'b0, 3'b010);  // R8
        trial(6'b010000, 1'b0, 3'b101);  // R8 disabled
        trial(6'b100000, 1'b0, 3'b100);  // R9
        trial(6'b100000, 1'b1, 3'b100);  // R9 masked
        // priority and blocking
        trial(6'b111111, 1'b0, 3'b111);  // R3 reset wins
        trial(6'b111110, 1'b1, 3'b111);  // R3 NMI wins
        trial(6'b010100, 1'b1, 3'b010);  // R10 masked IRQ blocks OC
        trial(6'b101000, 1'b0, 3'b100);  // R10 disabled IC blocks TO
        trial(6'b110000, 1'b0, 3'b011);  // R3 OC over TO
        trial(6'b000000, 1'b0, 3'b111);  // nothing pending

        // R2: requests pending but boundary low
        @(negedge clk);
        req = 6'b000010; boundary = 1'b0;
        @(negedge clk);
        check("R2", {take, clr, ack, vec}, '0);

        // R11: boundary held high, IRQ left pending -> take, gap, take
        @(negedge clk);
        req = 6'b000100; mask = 1'b0; boundary = 1'b1;
        @(negedge clk);
        check("R11", {31'd0, take}, 32'd1);
        @(negedge clk);
        check("R11", {31'd0, take}, 32'd0);
        @(negedge clk);
        check("R11", {take, clr, ack, vec}, {1'b1, 1'b0, 6'b000100, 16'hFFF8});
        boundary = 1'b0; req = '0;
        @(negedge clk);

        // constrained random: each request set with probability 1/4
        for (int n = 0; n < 400; n++) begin
            logic [5:0] r;
            for (int b = 0; b < 6; b++) r[b] = ($urandom % 4) == 0;
            trial(r, 1'($urandom % 2), 3'($urandom % 8));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule